// File: doc/BRIEF.md
# Decimal Ring-Counter Accumulator

This block is a signed decimal accumulator made of ten digit positions. Each position keeps its value in a ten-stage circular register where exactly one stage is set. Addition is done by counting. An operand arrives as ten BCD digits with a sign flag. During a fixed counting phase, each digit position receives as many advance pulses as the operand digit asks for, and each pulse moves the set stage forward by one. The value is never converted to binary.

A position that steps from 9 back to 0 latches a carry. After the counting phase, a separate carry phase hands the latched carries one position upward per cycle. A carry that makes another digit wrap keeps rippling until none is left, and only then does a one-cycle done pulse appear.

Negative values use a ten's-complement form together with a two-state sign position. The read-out value is the ten output digits minus the sign bit times 10^10. A negative operand is added as its complement: each digit receives 9 minus its magnitude in pulses, the least significant digit receives one more, and the sign position toggles. A carry out of the top digit toggles the sign position. A sticky overflow flag records any result that leaves the representable range.

Top module: `dec_ring_acc`

## Requirements
- R1: Every digit position holds exactly one set stage. After reset, each digit reads 0 and sign_o, ovf_o and busy_o are 0. The BCD output nibble at bits [4*i+3:4*i] of sum_bcd_o is the index of the set stage of digit i, with digit 0 the least significant.
- R2: Take a start with op_neg_i=0 and operand digit i equal to d (0..9). Each digit then advances by d positions, so the accumulated value grows by the operand magnitude.
- R3: A digit that steps from 9 to 0 passes a carry of one into the next higher digit. Carries ripple through any number of positions that sit at 9 before done_o is raised. Example: 9999999999 + 1 gives digits 0000000000.
- R4: The value is sum_bcd_o minus sign_o times 10^10, where sign_o=1 means negative. Take a start with op_neg_i=1. Digit i then receives 9-d pulses, digit 0 receives one extra pulse, and the sign toggles once, so the magnitude is subtracted. Example: 3 minus 8 reads sign_o=1 with digits 9999999995.
- R5: A carry out of the most significant digit toggles sign_o. ovf_o is set when the true signed result lies outside [-10^10, 10^10-1]. Once set, it stays set through later operations until a clear or reset.
- R6: A start accepted in idle makes busy_o high from the next cycle. done_o is high for exactly one cycle, 11+r cycles after the accepting edge, where r is the number of carry-ripple steps needed. busy_o is low while done_o is high.
- R7: start_i and clr_i are ignored while busy_o is high. The running operation finishes with the result of the original operand.
- R8: clr_i in idle sets every digit to 0 and clears sign_o and ovf_o on the next cycle. When clr_i and start_i are both high, the clear wins and no operation starts.
- R9: err_o is high whenever any digit register does not hold exactly one set stage. In normal operation it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin adding the operand (accepted in idle) |
| clr_i | input | 1 | Zero the accumulator and flags (accepted in idle) |
| op_neg_i | input | 1 | Operand sign, 1 = subtract |
| op_bcd_i | input | 4*NDIG | Operand magnitude, BCD, digit 0 in bits [3:0] |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse when all digits have settled |
| sum_bcd_o | output | 4*NDIG | Accumulated digits, BCD, ten's-complement form |
| sign_o | output | 1 | Sign position, 1 = negative |
| ovf_o | output | 1 | Sticky signed overflow |
| err_o | output | 1 | Some digit register is not one-hot |

## Verification
The bench runs several kinds of operand against a behavioural integer model:
- Positive operands with no wrap check plain counting.
- Pairs such as 5 then 6 check that a single carry is latched and applied.
- 9999999999 followed by 1 drives the longest ripple and a positive overflow, which separates a one-step carry from full propagation and also checks the exact done latency.
- Subtractions that cross zero, a negative zero and repeated large negative operands exercise the complement path and the negative overflow bound.
- Start and clear pulses during busy, plus a long random mix, show that stray requests leave the result untouched and that the model and the rings stay aligned across many sign changes.

// File: rtl/dra_pkg.sv
// Shared constants and types for the decimal ring-counter accumulator.
// Assumes decimal digits, so a ring has ten stages and read-out is 4-bit BCD.
package dra_pkg;
    localparam int RING_LEN = 10;
    localparam int DIG_W    = 4;
    localparam int TICK_W   = $clog2(RING_LEN + 1);
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_COUNT = 2'd1,
        PH_CARRY = 2'd2
    } phase_e;
endpackage

// File: rtl/dra_ring_digit.sv
// One decimal digit stored as a one-hot circular register.
// Each step moves the set stage up by one, and stage RING_LEN-1 wraps to stage 0.
// Assumes clr_i and step_i come from the sequencer and carry chain; clear wins.
module dra_ring_digit
    import dra_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr_i,
    input  logic                step_i,
    output logic [DIG_W-1:0]    value_o,
    output logic                at_top_o,
    output logic                bad_o
);
    logic [RING_LEN-1:0] stage_q;

    // Ring register: forced to stage 0 on reset or clear, rotates on a step.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            stage_q <= {{(RING_LEN-1){1'b0}}, 1'b1};
        end else if (step_i) begin
            stage_q <= {stage_q[RING_LEN-2:0], stage_q[RING_LEN-1]};
        end
    end

    // Encode the set stage into its BCD index.
    always_comb begin
        value_o = '0;
        for (int s = 0; s < RING_LEN; s++) begin
            if (stage_q[s]) value_o = value_o | DIG_W'(s);
        end
    end

    // Flag the top stage and any state that is not exactly one-hot.
    assign at_top_o = stage_q[RING_LEN-1];
    assign bad_o    = ($countones(stage_q) != 1);

    // R1
    ring_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(stage_q) == 1);

    // R2
    ring_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !clr_i && !at_top_o) |=> (value_o == DIG_W'($past(value_o) + 1'b1)));

    // R3
    ring_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !clr_i && at_top_o) |=> (value_o == '0));

    // R8
    ring_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (value_o == '0));
endmodule

// File: rtl/dra_pulse_gen.sv
// Converts a latched operand into per-digit pulse quotas and issues the pulses.
// A positive digit d needs d pulses. A negative operand needs 9-d pulses,
// with one more on digit 0. In tick t a digit pulses while t is below its quota.
// Assumes operand digits are valid BCD (0..9).
module dra_pulse_gen
    import dra_pkg::*;
#(
    parameter int NDIG = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_i,
    input  logic [DIG_W*NDIG-1:0]   op_bcd_i,
    input  logic                    op_neg_i,
    input  logic                    counting_i,
    input  logic [TICK_W-1:0]       tick_i,
    output logic [NDIG-1:0]         step_o
);
    localparam logic [TICK_W-1:0] TOP_VAL = TICK_W'(RING_LEN - 1);

    for (genvar g = 0; g < NDIG; g++) begin : g_dig
        localparam logic [TICK_W-1:0] EXTRA = (g == 0) ? TICK_W'(1) : TICK_W'(0);
        logic [TICK_W-1:0] quota_q;
        logic [TICK_W-1:0] mag;

        assign mag = TICK_W'(op_bcd_i[DIG_W*g +: DIG_W]);

        // Quota register: loaded when an operation is accepted.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                quota_q <= '0;
            end else if (load_i) begin
                quota_q <= op_neg_i ? (TOP_VAL - mag + EXTRA) : mag;
            end
        end

        // Pulse request for this digit in the current tick.
        assign step_o[g] = counting_i && (tick_i < quota_q);

        // R4
        quota_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            step_o[g] |-> (tick_i < TICK_W'(RING_LEN)));
    end
endmodule

// File: rtl/dra_carry_chain.sv
// Latches wrap carries during counting, then ripples them one position per cycle.
// A carry into a digit at its top stage re-latches a carry at that digit.
// A carry leaving the top digit is reported on msd_out_o.
// Assumes NDIG >= 2, and that counting and carry phases never overlap.
module dra_carry_chain
    import dra_pkg::*;
#(
    parameter int NDIG = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush_i,
    input  logic                carry_phase_i,
    input  logic [NDIG-1:0]     count_step_i,
    input  logic [NDIG-1:0]     at_top_i,
    output logic [NDIG-1:0]     carry_step_o,
    output logic                msd_out_o,
    output logic                pending_o
);
    logic [NDIG-1:0] latch_q;

    // Each latched carry feeds the next higher digit during the carry phase.
    always_comb begin
        carry_step_o = '0;
        msd_out_o    = 1'b0;
        if (carry_phase_i) begin
            carry_step_o = {latch_q[NDIG-2:0], 1'b0};
            msd_out_o    = latch_q[NDIG-1];
        end
    end

    // Carry latches: collect wraps while counting, then replace them with new wraps while rippling.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            latch_q <= '0;
        end else if (carry_phase_i) begin
            latch_q <= carry_step_o & at_top_i;
        end else begin
            latch_q <= latch_q | (count_step_i & at_top_i);
        end
    end

    assign pending_o = |latch_q;

    // R3
    ripple_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (carry_phase_i && !flush_i) |=> ($countones(latch_q) <= $past($countones(latch_q))));

    // R3
    ripple_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (carry_phase_i && !pending_o) |=> !pending_o);
endmodule

// File: rtl/dra_seq.sv
// Phase sequencer: idle, ten counting ticks, then carry ripple until nothing is pending.
// It also owns the sign position, the sticky overflow flag and the done pulse.
// Assumes start/clear are sampled only in idle, and that a clear beats a start.
module dra_seq
    import dra_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                clr_i,
    input  logic                op_neg_i,
    input  logic                pending_i,
    input  logic                msd_out_i,
    output logic                clr_acc_o,
    output logic                load_o,
    output logic                counting_o,
    output logic                carry_phase_o,
    output logic [TICK_W-1:0]   tick_o,
    output logic                busy_o,
    output logic                done_o,
    output logic                sign_o,
    output logic                ovf_o
);
    phase_e phase_q;
    logic   neg_q;
    logic   sign_start_q;
    logic   msd_seen_q;
    logic   idle;
    logic   finish;

    assign idle          = (phase_q == PH_IDLE);
    assign clr_acc_o     = idle && clr_i;
    assign load_o        = idle && start_i && !clr_i;
    assign counting_o    = (phase_q == PH_COUNT);
    assign carry_phase_o = (phase_q == PH_CARRY);
    assign finish        = carry_phase_o && !pending_i;
    assign busy_o        = !idle;

    // Phase and tick counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            tick_o  <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (load_o) begin
                        phase_q <= PH_COUNT;
                        tick_o  <= '0;
                    end
                end
                PH_COUNT: begin
                    tick_o <= tick_o + 1'b1;
                    if (tick_o == TICK_W'(RING_LEN - 1)) phase_q <= PH_CARRY;
                end
                PH_CARRY: begin
                    if (!pending_i) phase_q <= PH_IDLE;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // One-cycle done pulse once the carry chain is empty.
    always_ff @(posedge clk) begin
        if (!rst_n) done_o <= 1'b0;
        else        done_o <= finish;
    end

    // Per-operation context: operand sign, starting sign, top-digit carry seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            neg_q        <= 1'b0;
            sign_start_q <= 1'b0;
            msd_seen_q   <= 1'b0;
        end else if (load_o) begin
            neg_q        <= op_neg_i;
            sign_start_q <= sign_o;
            msd_seen_q   <= 1'b0;
        end else if (msd_out_i) begin
            msd_seen_q   <= 1'b1;
        end
    end

    // Sign position: toggled by a negative operand and by a carry out of the top digit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_acc_o) begin
            sign_o <= 1'b0;
        end else if ((counting_o && tick_o == '0 && neg_q) || msd_out_i) begin
            sign_o <= !sign_o;
        end
    end

    // Sticky overflow: operands of equal sign whose top carry disagrees with that sign.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_acc_o) begin
            ovf_o <= 1'b0;
        end else if (finish && (sign_start_q == neg_q) && (msd_seen_q != neg_q)) begin
            ovf_o <= 1'b1;
        end
    end

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R5
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !clr_i) |=> ovf_o);

    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !finish) |=> busy_o);

    // R8
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && clr_i) |=> (!busy_o && !sign_o && !ovf_o));
endmodule

// File: rtl/dec_ring_acc.sv
// Top level of the ten-digit signed decimal ring-counter accumulator.
// Wires the digit rings to the pulse generator, the carry chain and the sequencer.
// Read-out is BCD digits in ten's-complement form plus a sign position.
// Assumes operand digits are valid BCD.
module dec_ring_acc
    import dra_pkg::*;
#(
    parameter int NDIG = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic                    clr_i,
    input  logic                    op_neg_i,
    input  logic [DIG_W*NDIG-1:0]   op_bcd_i,
    output logic                    busy_o,
    output logic                    done_o,
    output logic [DIG_W*NDIG-1:0]   sum_bcd_o,
    output logic                    sign_o,
    output logic                    ovf_o,
    output logic                    err_o
);
    logic                clr_acc;
    logic                load;
    logic                counting;
    logic                carry_phase;
    logic [TICK_W-1:0]   tick;
    logic [NDIG-1:0]     count_step;
    logic [NDIG-1:0]     carry_step;
    logic [NDIG-1:0]     at_top;
    logic [NDIG-1:0]     bad;
    logic                msd_out;
    logic                pending;

    dra_seq u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .clr_i         (clr_i),
        .op_neg_i      (op_neg_i),
        .pending_i     (pending),
        .msd_out_i     (msd_out),
        .clr_acc_o     (clr_acc),
        .load_o        (load),
        .counting_o    (counting),
        .carry_phase_o (carry_phase),
        .tick_o        (tick),
        .busy_o        (busy_o),
        .done_o        (done_o),
        .sign_o        (sign_o),
        .ovf_o         (ovf_o)
    );

    dra_pulse_gen #(.NDIG(NDIG)) u_pulse (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .op_bcd_i   (op_bcd_i),
        .op_neg_i   (op_neg_i),
        .counting_i (counting),
        .tick_i     (tick),
        .step_o     (count_step)
    );

    dra_carry_chain #(.NDIG(NDIG)) u_carry (
        .clk           (clk),
        .rst_n         (rst_n),
        .flush_i       (clr_acc | load),
        .carry_phase_i (carry_phase),
        .count_step_i  (count_step),
        .at_top_i      (at_top),
        .carry_step_o  (carry_step),
        .msd_out_o     (msd_out),
        .pending_o     (pending)
    );

    for (genvar g = 0; g < NDIG; g++) begin : g_ring
        dra_ring_digit u_ring (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr_i    (clr_acc),
            .step_i   (count_step[g] | carry_step[g]),
            .value_o  (sum_bcd_o[DIG_W*g +: DIG_W]),
            .at_top_o (at_top[g]),
            .bad_o    (bad[g])
        );
    end

    // Error flag: any digit register out of its one-hot form.
    assign err_o = |bad;

    // R9
    no_bad_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !err_o);

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i && !clr_i) |=> ($stable(sum_bcd_o) && $stable(sign_o)));
endmodule

// File: tb/dec_ring_acc_tb_top.sv
// Self-checking bench: integer reference model, outputs compared at negedges.
module dec_ring_acc_tb_top;
    localparam int    NDIG = 10;
    localparam longint HALF = 64'd10000000000;
    localparam longint MODV = 64'd20000000000;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start_i = 1'b0;
    logic                 clr_i = 1'b0;
    logic                 op_neg_i = 1'b0;
    logic [4*NDIG-1:0]    op_bcd_i = '0;
    logic                 busy_o, done_o, sign_o, ovf_o, err_o;
    logic [4*NDIG-1:0]    sum_bcd_o;

    int     vectors = 0;
    int     fails = 0;
    longint acc_m = 0;
    bit     ovf_m = 1'b0;
    int     cyc = 0;

    always #4 clk = ~clk;

    dec_ring_acc #(.NDIG(NDIG)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .clr_i(clr_i),
        .op_neg_i(op_neg_i), .op_bcd_i(op_bcd_i), .busy_o(busy_o),
        .done_o(done_o), .sum_bcd_o(sum_bcd_o), .sign_o(sign_o),
        .ovf_o(ovf_o), .err_o(err_o)
    );

    task automatic chk(bit ok, string req, longint act, longint exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint bcd_to_int(logic [4*NDIG-1:0] b);
        longint v = 0;
        for (int i = NDIG - 1; i >= 0; i--) v = v * 10 + longint'(b[4*i +: 4]);
        return v;
    endfunction

    function automatic logic [4*NDIG-1:0] int_to_bcd(longint v);
        logic [4*NDIG-1:0] b = '0;
        for (int i = 0; i < NDIG; i++) begin
            b[4*i +: 4] = 4'(v % 10);
            v = v / 10;
        end
        return b;
    endfunction

    // Compare the visible value and flags against the model.
    task automatic cmp_state(string req);
        chk(bcd_to_int(sum_bcd_o) == acc_m % HALF, req, bcd_to_int(sum_bcd_o), acc_m % HALF);
        chk(sign_o == (acc_m >= HALF), req, sign_o, (acc_m >= HALF));
        chk(ovf_o == ovf_m, req, ovf_o, ovf_m);
        chk(err_o == 1'b0, "R9", err_o, 0);
    endtask

    // Add a signed magnitude; optional stray start/clear while busy.
    task automatic do_add(longint mag, bit neg, bit poke, string req);
        int d[NDIG];
        int n[NDIG];
        bit c[NDIG];
        bit nc[NDIG];
        int r = 0;
        int k = 0;
        bit any;
        bit seen = 1'b0;
        longint low = acc_m % HALF;
        longint v_old = (acc_m < HALF) ? acc_m : acc_m - MODV;
        longint tv;
        for (int i = 0; i < NDIG; i++) begin
            int od = int'((mag / (64'd10 ** i)) % 10);
            d[i] = int'((low / (64'd10 ** i)) % 10);
            n[i] = neg ? (9 - od + ((i == 0) ? 1 : 0)) : od;
            c[i] = (d[i] + n[i]) >= 10;
            d[i] = (d[i] + n[i]) % 10;
        end
        any = 1'b0;
        for (int i = 0; i < NDIG; i++) any |= c[i];
        while (any) begin
            r++;
            any = 1'b0;
            for (int i = 0; i < NDIG; i++) begin
                bit in_c = (i == 0) ? 1'b0 : c[i-1];
                nc[i] = in_c && (d[i] == 9);
                if (in_c) d[i] = (d[i] + 1) % 10;
            end
            for (int i = 0; i < NDIG; i++) begin
                c[i] = nc[i];
                any |= nc[i];
            end
        end
        tv = neg ? v_old - mag : v_old + mag;
        if (tv < -HALF || tv >= HALF) ovf_m = 1'b1;
        acc_m = ((tv % MODV) + MODV) % MODV;

        @(negedge clk);
        op_bcd_i = int_to_bcd(mag);
        op_neg_i = neg;
        start_i  = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R6", busy_o, 1);
        while (!seen && k < 40) begin
            @(negedge clk);
            k++;
            if (poke && k == 3) begin
                start_i  = 1'b1;
                op_bcd_i = int_to_bcd(64'd7777777777);
                op_neg_i = ~neg;
            end else if (poke && k == 5) begin
                clr_i = 1'b1;
            end else begin
                start_i = 1'b0;
                clr_i   = 1'b0;
            end
            if (err_o) chk(1'b0, "R9", err_o, 0);
            if (done_o) seen = 1'b1;
            else if (busy_o !== 1'b1) chk(1'b0, "R6", busy_o, 1);
        end
        start_i = 1'b0;
        clr_i   = 1'b0;
        chk(seen && k == 11 + r, "R6", k, 11 + r);
        chk(busy_o == 1'b0, "R6", busy_o, 0);
        cmp_state(req);
        @(negedge clk);
        chk(done_o == 1'b0, "R6", done_o, 0);
        cmp_state(poke ? "R7" : req);
    endtask

    task automatic do_clear(bit with_start);
        @(negedge clk);
        clr_i   = 1'b1;
        start_i = with_start;
        op_bcd_i = int_to_bcd(64'd42);
        op_neg_i = 1'b0;
        @(negedge clk);
        clr_i   = 1'b0;
        start_i = 1'b0;
        acc_m = 0;
        ovf_m = 1'b0;
        chk(busy_o == 1'b0, "R8", busy_o, 0);
        cmp_state("R8");
        @(negedge clk);
        chk(busy_o == 1'b0, "R8", busy_o, 0);
        cmp_state("R8");
    endtask

    // Watchdog: ends a hung run as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            vectors++;
            $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy_o == 1'b0, "R1", busy_o, 0);
        cmp_state("R1");

        do_add(64'd1234567890, 1'b0, 1'b0, "R2");
        do_add(64'd1111111111, 1'b0, 1'b0, "R2");
        do_clear(1'b0);
        do_add(64'd5, 1'b0, 1'b0, "R2");
        do_add(64'd6, 1'b0, 1'b0, "R3");
        do_clear(1'b0);
        do_add(64'd9999999999, 1'b0, 1'b0, "R2");
        do_add(64'd1, 1'b0, 1'b0, "R3");           // full ripple, R5 positive overflow
        do_add(64'd1, 1'b0, 1'b0, "R5");           // overflow stays set
        do_clear(1'b1);                             // R8 clear beats start
        do_add(64'd3, 1'b0, 1'b0, "R2");
        do_add(64'd8, 1'b1, 1'b0, "R4");           // 3 - 8 = -5
        do_add(64'd0, 1'b1, 1'b0, "R4");           // negative zero
        do_add(64'd5, 1'b0, 1'b0, "R4");           // back to zero, sign carries out
        do_add(64'd9999999999, 1'b1, 1'b0, "R4");
        do_add(64'd1, 1'b1, 1'b0, "R4");           // reaches -10^10
        do_add(64'd1, 1'b1, 1'b0, "R5");           // negative overflow
        do_clear(1'b0);
        do_add(64'd4444444444, 1'b0, 1'b1, "R7");
        do_add(64'd123, 1'b1, 1'b1, "R7");
        do_clear(1'b0);
        for (int t = 0; t < 60; t++) begin
            longint m = longint'($urandom % 100000) * 100000 + longint'($urandom % 100000);
            do_add(m, 1'($urandom % 2), 1'b0, "R4");
            if (t % 20 == 19) do_clear(1'b0);
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule